// File: doc/BRIEF.md
# Fractional-Step PWM Period Generator

This block sets the period of a PWM output for one LED driver channel. A 16-bit phase accumulator grows by a programmable step on every PWM clock. Each time the addition carries out of the top bit, a new period begins. The step does not have to be a power of two, so a period can last a fractional number of clocks on average. For example, a step of 176 gives periods of 372 or 373 clocks, which average 372.36.

Two inputs choose the step. A 4-bit frequency code picks a base step, and a 2-bit resolution code divides that base step by 1, 2, 4 or 8. Each halving of the step doubles the clocks per period. If the PWM clock is doubled at the same time, the output frequency stays the same and the duty word gains one bit of resolution. The block reports the duty resolution that is in effect. It drives its output high while the upper accumulator bits are below the duty word. A new frequency code, resolution code or duty word is applied only when a period wraps, so the output never contains a partial period.

Top module: `pwmfrac_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator clears to zero, `pwm_out` and `period_start` go low, and the frequency code, resolution code and duty word present at that edge are loaded as the active settings.
- R2: With resolution code 0, frequency codes 0 to 15 select the steps 64, 128, 176, 224, 256, 272, 288, 304, 320, 336, 352, 368, 384, 400, 448 and 512.
- R3: Resolution codes 1, 2 and 3 use one half, one quarter and one eighth of the resolution-code-0 step. The number of clocks between two period starts is therefore floor or ceil of 65536 divided by the active step.
- R4: `period_start` is high for exactly one cycle after each clock edge at which the accumulator sum carries out of bit 15.
- R5: `res_bits` gives the active duty resolution. With resolution code 0 it is 10 for frequency code 0, 9 for code 1, 8 for codes 2 to 4 and 7 for codes 5 to 15. Each step of the resolution code adds one bit, so the range is 7 to 13.
- R6: At each edge after reset, `pwm_out` takes the value (top R bits of the accumulator before that edge) < duty, where R is `res_bits`, and holds it for one cycle.
- R7: An active duty word of 0 keeps `pwm_out` low. An active duty word of 2^R or more keeps it high for the whole period.
- R8: The frequency code, resolution code and duty word are sampled only at an edge where the accumulator wraps. A change at any other time has no effect on `res_bits`, the current period length or the output of the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst | input | 1 | Synchronous active-high reset; settings are loaded while it is high |
| freq_code | input | 4 | Frequency selection code; selects the base step |
| res_code | input | 2 | Resolution code; right-shifts the base step by 0 to 3 bits |
| duty | input | DUTY_W (14) | Duty word, compared against the top R accumulator bits |
| pwm_out | output | 1 | Registered PWM output |
| period_start | output | 1 | One-cycle strobe that marks the start of each period |
| res_bits | output | 4 | Active duty resolution in bits |

## Verification
A wrong step or a corrupted accumulator shows up at the ports as a period-start strobe one or more cycles away from where it should be. The bench measures every period to the clock and compares the strobe on every cycle, so at the latest the error is caught at the end of the period in which it occurs, after at most 8192 clocks. An active setting loaded at the wrong moment shows up within one cycle, as a change in `res_bits` or in the output level while the strobe is low. A wrong comparator slice shows up in `pwm_out` on the first cycle where the faulty value and the correct value of the top bits fall on opposite sides of the duty word.

// File: rtl/pwmfrac_pkg.sv
package pwmfrac_pkg;

  localparam int FREQ_W  = 4;
  localparam int RCODE_W = 2;
  localparam int STEP_W  = 10;
  localparam int RES_W   = 4;
  localparam int RES_MIN = 7;
  localparam int RES_MAX = 13;

  typedef struct packed {
    logic [STEP_W-1:0] step;
    logic [RES_W-1:0]  res;
  } pwm_cfg_t;

  // step per clock for resolution code 0
  function automatic logic [STEP_W-1:0] base_step(input logic [FREQ_W-1:0] f);
    case (f)
      4'd0:    base_step = 10'd64;
      4'd1:    base_step = 10'd128;
      4'd2:    base_step = 10'd176;
      4'd3:    base_step = 10'd224;
      4'd4:    base_step = 10'd256;
      4'd5:    base_step = 10'd272;
      4'd6:    base_step = 10'd288;
      4'd7:    base_step = 10'd304;
      4'd8:    base_step = 10'd320;
      4'd9:    base_step = 10'd336;
      4'd10:   base_step = 10'd352;
      4'd11:   base_step = 10'd368;
      4'd12:   base_step = 10'd384;
      4'd13:   base_step = 10'd400;
      4'd14:   base_step = 10'd448;
      default: base_step = 10'd512;
    endcase
  endfunction

  // duty resolution for resolution code 0
  function automatic logic [RES_W-1:0] base_res(input logic [FREQ_W-1:0] f);
    if (f == 4'd0)      base_res = 4'd10;
    else if (f == 4'd1) base_res = 4'd9;
    else if (f <= 4'd4) base_res = 4'd8;
    else                base_res = 4'd7;
  endfunction

endpackage

// File: rtl/pwmfrac_step_sel.sv
module pwmfrac_step_sel
  import pwmfrac_pkg::*;
(
  input  logic [FREQ_W-1:0]  freq_code,
  input  logic [RCODE_W-1:0] res_code,
  output pwm_cfg_t           cfg
);

  logic [STEP_W-1:0] raw_step;
  logic [RES_W-1:0]  raw_res;

  always_comb begin
    raw_step = base_step(freq_code);
    raw_res  = base_res(freq_code);
    cfg.step = raw_step >> res_code;
    cfg.res  = raw_res + RES_W'(res_code);
  end

endmodule

// File: rtl/pwmfrac_accum.sv
module pwmfrac_accum
  import pwmfrac_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int DUTY_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  pwm_cfg_t          cfg_in,
  input  logic [DUTY_W-1:0] duty_in,
  output logic [ACC_W-1:0]  acc_q,
  output pwm_cfg_t          cfg_q,
  output logic [DUTY_W-1:0] duty_q,
  output logic              wrap_q
);

  localparam int SUM_W = ACC_W + 1;

  logic [SUM_W-1:0] sum;
  logic             carry;

  always_comb begin
    sum   = {1'b0, acc_q} + SUM_W'(cfg_q.step);
    carry = sum[ACC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      wrap_q <= 1'b0;
      cfg_q  <= cfg_in;
      duty_q <= duty_in;
    end else begin
      acc_q  <= sum[ACC_W-1:0];
      wrap_q <= carry;
      if (carry) begin
        cfg_q  <= cfg_in;
        duty_q <= duty_in;
      end
    end
  end

endmodule

// File: rtl/pwmfrac_cmp.sv
module pwmfrac_cmp
  import pwmfrac_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int DUTY_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ACC_W-1:0]  acc_q,
  input  logic [RES_W-1:0]  res,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_q
);

  localparam int CMP_W  = (ACC_W > DUTY_W) ? ACC_W : DUTY_W;
  localparam int N_RES  = RES_MAX - RES_MIN + 1;

  logic [CMP_W-1:0] top_by_res [N_RES];
  logic [CMP_W-1:0] top_sel;
  logic             hit;

  for (genvar g = RES_MIN; g <= RES_MAX; g++) begin : g_slice
    assign top_by_res[g-RES_MIN] = CMP_W'(acc_q[ACC_W-1 -: g]);
  end

  always_comb begin
    top_sel = '0;
    for (int i = 0; i < N_RES; i++) begin
      if (32'(res) == i + RES_MIN) top_sel = top_by_res[i];
    end
    hit = top_sel < CMP_W'(duty);
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else     pwm_q <= hit;
  end

endmodule

// File: rtl/pwmfrac_gen.sv
module pwmfrac_gen
  import pwmfrac_pkg::*;
#(
  parameter int ACC_W  = 16,
  parameter int DUTY_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        freq_code,
  input  logic [1:0]        res_code,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm_out,
  output logic              period_start,
  output logic [3:0]        res_bits
);

  pwm_cfg_t          cfg_next;
  pwm_cfg_t          cfg_cur;
  logic [ACC_W-1:0]  acc_cur;
  logic [DUTY_W-1:0] duty_cur;

  pwmfrac_step_sel u_sel (
    .freq_code (freq_code),
    .res_code  (res_code),
    .cfg       (cfg_next)
  );

  pwmfrac_accum #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .cfg_in  (cfg_next),
    .duty_in (duty),
    .acc_q   (acc_cur),
    .cfg_q   (cfg_cur),
    .duty_q  (duty_cur),
    .wrap_q  (period_start)
  );

  pwmfrac_cmp #(.ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_cmp (
    .clk   (clk),
    .rst   (rst),
    .acc_q (acc_cur),
    .res   (cfg_cur.res),
    .duty  (duty_cur),
    .pwm_q (pwm_out)
  );

  assign res_bits = cfg_cur.res;

endmodule

// File: rtl/pwmfrac_gen_chk.sv
module pwmfrac_gen_chk #(
  parameter int DUTY_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              pwm_out,
  input logic              period_start,
  input logic [3:0]        res_bits,
  input logic [DUTY_W-1:0] duty_cur
);

  // the smallest period is 128 clocks, so a strobe never repeats at once
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    period_start |=> !period_start);

  assert_res_only_at_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(res_bits)) |-> period_start);

  assert_res_range_R5: assert property (@(posedge clk) disable iff (rst)
    (res_bits >= 4'd7) && (res_bits <= 4'd13));

  assert_zero_duty_low_R7: assert property (@(posedge clk) disable iff (rst)
    (duty_cur == '0) |=> !pwm_out);

  assert_full_duty_high_R7: assert property (@(posedge clk) disable iff (rst)
    (32'(duty_cur) >= (32'd1 << res_bits)) |=> pwm_out);

endmodule

bind pwmfrac_gen pwmfrac_gen_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwm_out      (pwm_out),
  .period_start (period_start),
  .res_bits     (res_bits),
  .duty_cur     (duty_cur)
);

// File: tb/pwmfrac_gen_test.sv
module pwmfrac_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int DUTY_W     = 14;
  localparam int WD_CYCLES  = 150000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [3:0]        freq_code = 4'd0;
  logic [1:0]        res_code = 2'd0;
  logic [DUTY_W-1:0] duty = '0;
  logic              pwm_out;
  logic              period_start;
  logic [3:0]        res_bits;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwmfrac_gen #(.ACC_W(16), .DUTY_W(DUTY_W)) uut (
    .clk(clk), .rst(rst), .freq_code(freq_code), .res_code(res_code),
    .duty(duty), .pwm_out(pwm_out), .period_start(period_start), .res_bits(res_bits)
  );

  // ---------------- reference model ----------------
  function automatic int ref_step0(int f);
    int t [16] = '{64, 128, 176, 224, 256, 272, 288, 304,
                   320, 336, 352, 368, 384, 400, 448, 512};
    return t[f];
  endfunction

  function automatic int ref_res0(int f);
    if (f == 0) return 10;
    if (f == 1) return 9;
    if (f <= 4) return 8;
    return 7;
  endfunction

  int m_acc, m_step, m_res, m_duty;
  bit m_pwm, m_start;

  task automatic m_load();
    m_step = ref_step0(int'(freq_code)) / (1 << res_code);
    m_res  = ref_res0(int'(freq_code)) + int'(res_code);
    m_duty = int'(duty);
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_pwm = 0; m_start = 0;
      m_load();
    end else begin
      int sum;
      sum     = m_acc + m_step;
      m_pwm   = (m_acc >> (16 - m_res)) < m_duty;
      m_start = (sum >= 65536);
      m_acc   = sum % 65536;
      if (m_start) m_load();
    end
  end

  // ---------------- check helpers ----------------
  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  int cyc = 0;
  int last_start = -1;
  int last_iv = 0;
  int hi_acc = 0;
  int last_hi = 0;

  // one cycle, compared at the falling edge
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (!rst) begin
      check(pwm_out == m_pwm, "R6 pwm_out", int'(pwm_out), int'(m_pwm));
      check(period_start == m_start, "R4 period_start", int'(period_start), int'(m_start));
      check(int'(res_bits) == m_res, "R5 res_bits", int'(res_bits), m_res);
      if (period_start) begin
        if (last_start >= 0) last_iv = cyc - last_start;
        last_start = cyc;
        last_hi = hi_acc;
        hi_acc = 0;
      end
      if (pwm_out) hi_acc++;
    end
  endtask

  task automatic wait_strobe();
    do tick(); while (!period_start);
  endtask

  task automatic measure(int n, int lo, int hi, string req);
    wait_strobe();
    wait_strobe();
    for (int i = 0; i < n; i++) begin
      wait_strobe();
      check(last_iv >= lo && last_iv <= hi, req, last_iv, lo);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    freq_code = 4'd0; res_code = 2'd0; duty = 14'd512;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state, settings loaded during reset
    check(pwm_out == 1'b0, "R1 pwm_out in reset", int'(pwm_out), 0);
    check(period_start == 1'b0, "R1 period_start in reset", int'(period_start), 0);
    check(res_bits == 4'd10, "R1 res_bits in reset", int'(res_bits), 10);
    rst = 1'b0;

    // R2: code 0 step 64 -> 1024 clocks, res 10
    measure(3, 1024, 1024, "R2 period code0");
    check(res_bits == 4'd10, "R5 res code0", int'(res_bits), 10);
    // R6: duty 512 of 1024 -> half high
    check(last_hi == 512, "R6 high count code0", last_hi, 512);

    // R2: code 15 step 512 -> 128 clocks, res 7
    freq_code = 4'd15; duty = 14'd32;
    measure(3, 128, 128, "R2 period code15");
    check(res_bits == 4'd7, "R5 res code15", int'(res_bits), 7);
    check(last_hi == 32, "R6 high count code15", last_hi, 32);

    // R3: code 2 step 176 -> 372 or 373 clocks
    freq_code = 4'd2; duty = 14'd100;
    measure(10, 372, 373, "R3 fractional period");
    check(res_bits == 4'd8, "R5 res code2", int'(res_bits), 8);

    // R3: code 15 with resolution code 3 -> step 64, res 10
    freq_code = 4'd15; res_code = 2'd3; duty = 14'd700;
    measure(2, 1024, 1024, "R3 step eighth");
    check(res_bits == 4'd10, "R5 res code15 r3", int'(res_bits), 10);

    // R3/R5: code 1 with resolution code 1 -> step 64, res 10
    freq_code = 4'd1; res_code = 2'd1; duty = 14'd3;
    measure(2, 1024, 1024, "R3 step half");
    check(res_bits == 4'd10, "R5 res code1 r1", int'(res_bits), 10);

    // R7: duty zero keeps the output low
    freq_code = 4'd15; res_code = 2'd0; duty = 14'd0;
    measure(2, 128, 128, "R2 period code15 again");
    check(last_hi == 0, "R7 zero duty high count", last_hi, 0);
    // R7: full scale keeps the output high for the whole period
    duty = 14'd128;
    measure(2, 128, 128, "R2 period code15 full");
    check(last_hi == 128, "R7 full duty high count", last_hi, 128);
    duty = 14'd8191;
    measure(1, 128, 128, "R2 period code15 over");
    check(last_hi == 128, "R7 over-range duty high count", last_hi, 128);

    // R8: a mid-period change waits for the next wrap
    freq_code = 4'd0; duty = 14'd256;
    wait_strobe();
    wait_strobe();
    repeat (10) tick();
    freq_code = 4'd15; res_code = 2'd2; duty = 14'd0;
    tick();
    check(res_bits == 4'd10, "R8 res unchanged mid-period", int'(res_bits), 10);
    check(pwm_out == 1'b1, "R8 output unchanged mid-period", int'(pwm_out), 1);
    wait_strobe();
    check(last_iv == 1024, "R8 current period length kept", last_iv, 1024);
    check(res_bits == 4'd9, "R8 new res at wrap", int'(res_bits), 9);
    wait_strobe();
    check(last_iv == 512, "R8 new period length", last_iv, 512);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule